// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the register file of a multi-channel peripheral DMA controller. Software reaches it over a plain 32-bit register bus: an address, write data, a write strobe, and read data that is returned combinationally. It holds three global control words and a channel-control word. For every channel it also holds a next-command address and an 8-bit semaphore counter. Each control word has three addresses. The plain address overwrites the word, the address at +0x4 ORs the written bits in, and the address at +0x8 clears the bits that are written as ones.

The bank drives the channel engines directly. It gives them per-channel freeze levels, one-cycle soft-reset pulses, a one-cycle kick pulse that goes with each channel's start address, and the live semaphore counts. It also drives the burst-mode controls and the per-channel interrupt enables. An engine lowers its own semaphore through a decrement strobe.

The `LEGACY` parameter selects between two register layouts:
- **Current layout:** the channel registers start at 0x110 and 0x140, and freeze and reset live in the channel-control word at 0x030.
- **Older layout:** the channel registers start at 0x050 and 0x080, freeze and reset live in control word 0, and 0x030 is not mapped.

In both layouts the channel blocks repeat every 0x70 bytes.

Top module: `dmarb_regbank`

## Requirements
- R1: After reset, every control word, next-command address and semaphore count reads 0, and every output is 0.
- R2: A write to a control word's plain address (0x000, 0x010, 0x020, or 0x030 in the current layout) replaces the whole word. A read at that address returns the stored word.
- R3: A write to base+0x4 ORs the write data into the word. A write to base+0x8 clears every bit that is 1 in the write data. No other bits change.
- R4: chan_freeze[n] equals bit n of the channel-control word, and it holds its value until that word is written. The channel-control word is 0x030 in the current layout and control word 0 in the older layout.
- R5: Writing a 1 into bit 16+n of the channel-control word makes chan_reset[n] high for exactly the one cycle after the write. That bit reads back as 0 from the following cycle on, and the freeze bits are unaffected unless the write itself changes them.
- R6: Bit 28 of control word 0 drives burst_en and bit 29 drives burst8_en. Both are ordinary bits that do not self-clear, also in the older layout, where they take precedence over the reset field at those positions.
- R7: irq_enable[n] equals bit 16+n of control word 1 (0x010).
- R8: The next-command address of channel n is a 32-bit read/write register at 0x110+n*0x70, or 0x050+n*0x70 in the older layout. Its value is driven on chan_start_addr[n*32 +: 32].
- R9: The semaphore of channel n is at 0x140+n*0x70, or 0x080+n*0x70 in the older layout. A write adds write-data bits [7:0] to the count and saturates at 255. A read returns the count in bits [7:0] with zeros above.
- R10: A sema_dec[n] strobe subtracts one from channel n's count, applied after any add in the same cycle. A count of 0 stays at 0.
- R11: A write to channel n's semaphore with nonzero bits [7:0] makes chan_kick[n] high for one cycle, the cycle after the write. A write with zero bits [7:0] gives no kick.
- R12: Writes to unmapped addresses change nothing, and reads from them return 0. In the older layout, 0x030 and its aliases are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sema_dec | input | NCH | Per-channel semaphore decrement strobe |
| chan_freeze | output | NCH | Per-channel freeze level |
| chan_reset | output | NCH | Per-channel one-cycle soft-reset pulse |
| chan_kick | output | NCH | Per-channel one-cycle start pulse |
| chan_start_addr | output | NCH*32 | Per-channel next-command address |
| sema_count | output | NCH*SW | Per-channel semaphore count |
| irq_enable | output | NCH | Per-channel interrupt enable |
| burst_en | output | 1 | Burst enable |
| burst8_en | output | 1 | 8-beat burst enable |

## Verification
The bench builds two copies of the block.

The first uses the current layout with all 16 channels. With it the bench sweeps every bit of every control word through the set and clear aliases, every channel's freeze and reset position, and every channel's address and semaphore registers.

The second uses the older layout with 4 channels. It brings within reach the relocated channel bases, the freeze and reset field that shares control word 0 with the burst bits, and the unmapped 0x030 word.

Semaphore sequences cover saturation at 255, draining to zero, a decrement at zero, and an add and a decrement in the same cycle.

// File: rtl/dmarb_pkg.sv
`timescale 1ns/1ps
package dmarb_pkg;

    localparam int          DW         = 32;
    localparam logic [31:0] CH_STRIDE  = 32'h70;

    localparam logic [31:0] OFS_WORD0  = 32'h000;
    localparam logic [31:0] OFS_WORD1  = 32'h010;
    localparam logic [31:0] OFS_WORD2  = 32'h020;
    localparam logic [31:0] OFS_CHCTL  = 32'h030;

    localparam logic [31:0] ALIAS_SET  = 32'h4;
    localparam logic [31:0] ALIAS_CLR  = 32'h8;

    localparam int          RST_LSB    = 16;
    localparam int          IRQEN_LSB  = 16;
    localparam int          BURST_BIT  = 28;
    localparam int          BURST8_BIT = 29;

    // self-clearing reset field, per layout
    localparam logic [31:0] RST_FIELD_NEW = 32'hFFFF_0000;
    localparam logic [31:0] RST_FIELD_OLD = 32'hCFFF_0000;

    typedef enum logic [1:0] {
        WOP_NONE,
        WOP_LOAD,
        WOP_SET,
        WOP_CLR
    } wop_e;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
    } bus_req_t;

    function automatic logic [31:0] nxt_base(input bit legacy);
        return legacy ? 32'h050 : 32'h110;
    endfunction

    function automatic logic [31:0] sema_base(input bit legacy);
        return legacy ? 32'h080 : 32'h140;
    endfunction

    function automatic wop_e alias_op(input logic [31:0] a, input logic [31:0] base);
        if (a == base)                  return WOP_LOAD;
        else if (a == base + ALIAS_SET) return WOP_SET;
        else if (a == base + ALIAS_CLR) return WOP_CLR;
        else                            return WOP_NONE;
    endfunction

    function automatic logic [31:0] apply_op(input wop_e op, input logic [31:0] old,
                                             input logic [31:0] data);
        case (op)
            WOP_LOAD: return data;
            WOP_SET:  return old | data;
            WOP_CLR:  return old & ~data;
            default:  return old;
        endcase
    endfunction

endpackage

// File: rtl/dmarb_ctl_word.sv
`timescale 1ns/1ps
module dmarb_ctl_word
    import dmarb_pkg::*;
#(
    parameter logic [31:0] BASE    = 32'h0,
    parameter bit          PRESENT = 1'b1,
    parameter logic [31:0] SC_MASK = 32'h0
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic [DW-1:0] word,
    output logic     rd_hit
);

    wop_e wr_op;
    wop_e dec_op;

    always_comb begin
        dec_op = alias_op(req.addr, BASE);
        wr_op  = WOP_NONE;
        if (PRESENT && req.we)
            wr_op = dec_op;
    end

    assign rd_hit = PRESENT && (dec_op != WOP_NONE);

    // self-clearing bits live for exactly one cycle
    always_ff @(posedge clk) begin
        if (rst)
            word <= '0;
        else
            word <= apply_op(wr_op, word & ~SC_MASK, req.wdata);
    end

endmodule

// File: rtl/dmarb_chan_slot.sv
`timescale 1ns/1ps
module dmarb_chan_slot
    import dmarb_pkg::*;
#(
    parameter int          SW       = 8,
    parameter logic [31:0] NXT_ADDR = 32'h110,
    parameter logic [31:0] SEM_ADDR = 32'h140
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    input  logic          dec,
    output logic [DW-1:0] start_addr,
    output logic [SW-1:0] count,
    output logic          kick,
    output logic [DW-1:0] rd_data
);

    localparam logic [SW:0] MAXC = {1'b0, {SW{1'b1}}};

    logic          nxt_hit;
    logic          sem_hit;
    logic [SW-1:0] add_val;
    logic [SW:0]   sum_raw;
    logic [SW:0]   sum_dec;
    logic [SW-1:0] count_d;

    assign nxt_hit = (req.addr == NXT_ADDR);
    assign sem_hit = (req.addr == SEM_ADDR);

    always_comb begin
        add_val = (req.we && sem_hit) ? req.wdata[SW-1:0] : '0;
        sum_raw = {1'b0, count} + {1'b0, add_val};
        sum_dec = (dec && (sum_raw != '0)) ? sum_raw - 1'b1 : sum_raw;
        count_d = (sum_dec > MAXC) ? {SW{1'b1}} : sum_dec[SW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_addr <= '0;
            count      <= '0;
            kick       <= 1'b0;
        end else begin
            if (req.we && nxt_hit)
                start_addr <= req.wdata;
            count <= count_d;
            kick  <= req.we && sem_hit && (req.wdata[SW-1:0] != '0);
        end
    end

    always_comb begin
        rd_data = '0;
        if (nxt_hit)
            rd_data = start_addr;
        else if (sem_hit)
            rd_data[SW-1:0] = count;
    end

endmodule

// File: rtl/dmarb_regbank.sv
`timescale 1ns/1ps
module dmarb_regbank
    import dmarb_pkg::*;
#(
    parameter int NCH    = 16,
    parameter bit LEGACY = 1'b0,
    parameter int AW     = 12,
    parameter int SW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    sema_dec,
    output logic [NCH-1:0]    chan_freeze,
    output logic [NCH-1:0]    chan_reset,
    output logic [NCH-1:0]    chan_kick,
    output logic [NCH*32-1:0] chan_start_addr,
    output logic [NCH*SW-1:0] sema_count,
    output logic [NCH-1:0]    irq_enable,
    output logic              burst_en,
    output logic              burst8_en
);

    localparam logic [31:0] NXT0     = nxt_base(LEGACY);
    localparam logic [31:0] SEM0     = sema_base(LEGACY);
    localparam logic [31:0] W0_SC    = LEGACY ? RST_FIELD_OLD : 32'h0;
    localparam logic [31:0] RST_ALLOW = LEGACY ? RST_FIELD_OLD : RST_FIELD_NEW;

    bus_req_t    req;
    logic [31:0] w0, w1, w2, wcc;
    logic        h0, h1, h2, hcc;
    logic [31:0] chctl;
    logic [31:0] ch_rd [NCH];

    assign req.we    = bus_we;
    assign req.addr  = 32'(bus_addr);
    assign req.wdata = bus_wdata;

    dmarb_ctl_word #(.BASE(OFS_WORD0), .PRESENT(1'b1), .SC_MASK(W0_SC)) u_w0 (
        .clk(clk), .rst(rst), .req(req), .word(w0), .rd_hit(h0));

    dmarb_ctl_word #(.BASE(OFS_WORD1), .PRESENT(1'b1), .SC_MASK(32'h0)) u_w1 (
        .clk(clk), .rst(rst), .req(req), .word(w1), .rd_hit(h1));

    dmarb_ctl_word #(.BASE(OFS_WORD2), .PRESENT(1'b1), .SC_MASK(32'h0)) u_w2 (
        .clk(clk), .rst(rst), .req(req), .word(w2), .rd_hit(h2));

    dmarb_ctl_word #(.BASE(OFS_CHCTL), .PRESENT(!LEGACY), .SC_MASK(RST_FIELD_NEW)) u_wcc (
        .clk(clk), .rst(rst), .req(req), .word(wcc), .rd_hit(hcc));

    generate
        if (LEGACY) begin : g_ctl_old
            assign chctl = w0;
        end else begin : g_ctl_new
            assign chctl = wcc;
        end
    endgenerate

    assign chan_freeze = chctl[NCH-1:0];
    assign chan_reset  = chctl[RST_LSB +: NCH] & RST_ALLOW[RST_LSB +: NCH];
    assign irq_enable  = w1[IRQEN_LSB +: NCH];
    assign burst_en    = w0[BURST_BIT];
    assign burst8_en   = w0[BURST8_BIT];

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            dmarb_chan_slot #(
                .SW(SW),
                .NXT_ADDR(NXT0 + 32'(n) * CH_STRIDE),
                .SEM_ADDR(SEM0 + 32'(n) * CH_STRIDE)
            ) u_slot (
                .clk(clk),
                .rst(rst),
                .req(req),
                .dec(sema_dec[n]),
                .start_addr(chan_start_addr[n*32 +: 32]),
                .count(sema_count[n*SW +: SW]),
                .kick(chan_kick[n]),
                .rd_data(ch_rd[n])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (h0)  bus_rdata = bus_rdata | w0;
        if (h1)  bus_rdata = bus_rdata | w1;
        if (h2)  bus_rdata = bus_rdata | w2;
        if (hcc) bus_rdata = bus_rdata | wcc;
        for (int n = 0; n < NCH; n++)
            bus_rdata = bus_rdata | ch_rd[n];
    end

endmodule

// File: rtl/dmarb_checker.sv
`timescale 1ns/1ps
module dmarb_checker #(
    parameter int NCH = 16,
    parameter int SW  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [NCH-1:0]    sema_dec,
    input logic [NCH-1:0]    chan_freeze,
    input logic [NCH-1:0]    chan_reset,
    input logic [NCH-1:0]    chan_kick,
    input logic [NCH*SW-1:0] sema_count,
    input logic [NCH-1:0]    irq_enable,
    input logic              burst_en,
    input logic              burst8_en
);

    p_reset_needs_write_r5: assert property (@(posedge clk) disable iff (rst)
        (chan_reset != '0) |-> $past(bus_we));

    p_reset_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        ((chan_reset != '0) && !bus_we) |=> (chan_reset == '0));

    p_kick_needs_write_r11: assert property (@(posedge clk) disable iff (rst)
        (chan_kick != '0) |-> $past(bus_we));

    p_kick_one_cycle_r11: assert property (@(posedge clk) disable iff (rst)
        ((chan_kick != '0) && !bus_we) |=> (chan_kick == '0));

    p_sema_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(bus_we) && ($past(sema_dec) == '0)) |-> $stable(sema_count));

    p_freeze_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_we) |-> $stable(chan_freeze));

    p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_we) |-> $stable(irq_enable));

    p_burst_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_we) |-> $stable({burst_en, burst8_en}));

endmodule

bind dmarb_regbank dmarb_checker #(.NCH(NCH), .SW(SW)) u_chk (
    .clk(clk),
    .rst(rst),
    .bus_we(bus_we),
    .sema_dec(sema_dec),
    .chan_freeze(chan_freeze),
    .chan_reset(chan_reset),
    .chan_kick(chan_kick),
    .sema_count(sema_count),
    .irq_enable(irq_enable),
    .burst_en(burst_en),
    .burst8_en(burst8_en)
);

// File: tb/sim_dmarb_regbank.sv
`timescale 1ns/1ps
module sim_dmarb_regbank;

    localparam int N0 = 16;
    localparam int N1 = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [11:0] a0 = '0, a1 = '0;
    logic [31:0] d0 = '0, d1 = '0;
    logic        we0 = 1'b0, we1 = 1'b0;
    logic [31:0] r0, r1;
    logic [N0-1:0] dec0 = '0;
    logic [N1-1:0] dec1 = '0;
    logic [N0-1:0] frz0, rst0, kick0, irq0;
    logic [N1-1:0] frz1, rst1, kick1, irq1;
    logic [N0*32-1:0] sa0;
    logic [N1*32-1:0] sa1;
    logic [N0*8-1:0]  sc0;
    logic [N1*8-1:0]  sc1;
    logic b0, b80, b1, b81;

    dmarb_regbank #(.NCH(N0), .LEGACY(1'b0)) u0 (
        .clk(clk), .rst(rst), .bus_addr(a0), .bus_wdata(d0), .bus_we(we0),
        .bus_rdata(r0), .sema_dec(dec0), .chan_freeze(frz0), .chan_reset(rst0),
        .chan_kick(kick0), .chan_start_addr(sa0), .sema_count(sc0),
        .irq_enable(irq0), .burst_en(b0), .burst8_en(b80));

    dmarb_regbank #(.NCH(N1), .LEGACY(1'b1)) u1 (
        .clk(clk), .rst(rst), .bus_addr(a1), .bus_wdata(d1), .bus_we(we1),
        .bus_rdata(r1), .sema_dec(dec1), .chan_freeze(frz1), .chan_reset(rst1),
        .chan_kick(kick1), .chan_start_addr(sa1), .sema_count(sc1),
        .irq_enable(irq1), .burst_en(b1), .burst8_en(b81));

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic wr(input int u, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        if (u == 0) begin a0 = a; d0 = d; we0 = 1'b1; end
        else        begin a1 = a; d1 = d; we1 = 1'b1; end
        @(negedge clk);
        we0 = 1'b0; we1 = 1'b0;
        #1;
    endtask

    task automatic rd(input int u, input logic [11:0] a, output logic [31:0] v);
        if (u == 0) a0 = a; else a1 = a;
        #0.5;
        v = (u == 0) ? r0 : r1;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired before end of test");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] acc;
        logic [11:0] wa [3];
        wa[0] = 12'h000; wa[1] = 12'h010; wa[2] = 12'h020;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R1: reset state
        for (int k = 0; k < 3; k++) begin
            rd(0, wa[k], v); chk("R1 u0 word", v, 0);
            rd(1, wa[k], v); chk("R1 u1 word", v, 0);
        end
        rd(0, 12'h030, v); chk("R1 chctl", v, 0);
        for (int n = 0; n < N0; n++) begin
            rd(0, 12'(32'h110 + n*32'h70), v); chk("R1 nxt", v, 0);
            rd(0, 12'(32'h140 + n*32'h70), v); chk("R1 sema", v, 0);
        end
        chk("R1 outputs", {frz0, rst0, kick0, irq0}, 0);
        chk("R1 counts", sc0[31:0] | sc0[127:96], 0);
        chk("R1 burst", {30'd0, b0, b80}, 0);
        chk("R1 legacy outputs", {16'd0, frz1, rst1, kick1, irq1}, 0);

        // R2: plain overwrite of each control word
        for (int k = 0; k < 3; k++) begin
            wr(0, wa[k], 32'hA5C3_0F1E + 32'(k));
            rd(0, wa[k], v); chk("R2 load", v, 32'hA5C3_0F1E + 32'(k));
            wr(0, wa[k], 32'h0000_1234);
            rd(0, wa[k], v); chk("R2 reload", v, 32'h0000_1234);
            wr(0, wa[k], 32'h0);
        end
        wr(0, 12'h030, 32'h0000_5A5A);
        rd(0, 12'h030, v); chk("R2 chctl load", v, 32'h0000_5A5A);
        chk("R4 freeze from load", {16'd0, frz0}, 32'h5A5A);
        wr(0, 12'h030, 32'h0);

        // R3 / R6 / R7: set and clear alias sweep over every bit
        for (int k = 0; k < 3; k++) begin
            acc = '0;
            for (int b = 0; b < 32; b++) begin
                wr(0, wa[k] + 12'h4, 32'h1 << b);
                acc = acc | (32'h1 << b);
                rd(0, wa[k], v); chk("R3 set alias", v, acc);
                if (k == 0) chk("R6 burst", {30'd0, b80, b0}, {30'd0, acc[29], acc[28]});
                if (k == 1) chk("R7 irq enable", {16'd0, irq0}, {16'd0, acc[31:16]});
            end
            for (int b = 0; b < 32; b++) begin
                wr(0, wa[k] + 12'h8, 32'h1 << b);
                acc = acc & ~(32'h1 << b);
                rd(0, wa[k], v); chk("R3 clr alias", v, acc);
                if (k == 1) chk("R7 irq enable", {16'd0, irq0}, {16'd0, acc[31:16]});
            end
        end
        wr(0, 12'h000, 32'hFFFF_FFFF);
        step();
        rd(0, 12'h000, v); chk("R6 word0 no self-clear new", v, 32'hFFFF_FFFF);
        wr(0, 12'h000, 32'h0);

        // R4: freeze per channel
        acc = '0;
        for (int n = 0; n < N0; n++) begin
            wr(0, 12'h034, 32'h1 << n);
            acc = acc | (32'h1 << n);
            chk("R4 freeze set", {16'd0, frz0}, acc);
        end
        for (int n = 0; n < N0; n++) begin
            wr(0, 12'h038, 32'h1 << n);
            acc = acc & ~(32'h1 << n);
            chk("R4 freeze clr", {16'd0, frz0}, acc);
        end

        // R5: reset pulse per channel
        for (int n = 0; n < N0; n++) begin
            wr(0, 12'h034, 32'h1 << (16 + n));
            chk("R5 pulse", {16'd0, rst0}, 32'h1 << n);
            rd(0, 12'h030, v); chk("R5 bit during pulse", v, 32'h1 << (16 + n));
            step();
            chk("R5 pulse ends", {16'd0, rst0}, 0);
            rd(0, 12'h030, v); chk("R5 self-cleared", v, 0);
        end
        wr(0, 12'h030, 32'h0000_00FF);
        wr(0, 12'h034, 32'h0008_0000);
        chk("R5 pulse ch3", {16'd0, rst0}, 32'h8);
        chk("R5 freeze kept", {16'd0, frz0}, 32'hFF);
        step();
        chk("R5 freeze kept after", {16'd0, frz0}, 32'hFF);
        wr(0, 12'h030, 32'h0001_0000);
        chk("R5 load pulse ch0", {16'd0, rst0}, 32'h1);
        chk("R4 freeze overwritten", {16'd0, frz0}, 0);

        // R8: next-command address per channel
        for (int n = 0; n < N0; n++) begin
            wr(0, 12'(32'h110 + n*32'h70), 32'h8000_0000 + 32'(n) * 32'h0101_0044);
        end
        for (int n = 0; n < N0; n++) begin
            rd(0, 12'(32'h110 + n*32'h70), v);
            chk("R8 nxt readback", v, 32'h8000_0000 + 32'(n) * 32'h0101_0044);
            chk("R8 start addr", sa0[n*32 +: 32], 32'h8000_0000 + 32'(n) * 32'h0101_0044);
        end

        // R9 / R10 / R11: semaphore per channel
        for (int n = 0; n < N0; n++) begin
            logic [11:0] sa;
            sa = 12'(32'h140 + n*32'h70);
            wr(0, sa, 32'h3);
            chk("R11 kick", {16'd0, kick0}, 32'h1 << n);
            chk("R9 add 3", {24'd0, sc0[n*8 +: 8]}, 3);
            step();
            chk("R11 kick ends", {16'd0, kick0}, 0);
            wr(0, sa, 32'hFFFF_FF05);
            rd(0, sa, v); chk("R9 add 5 low byte", v, 8);
            @(negedge clk); dec0 = 16'(1 << n);
            @(negedge clk); dec0 = '0; #1;
            chk("R10 dec", {24'd0, sc0[n*8 +: 8]}, 7);
            wr(0, sa, 32'd250);
            rd(0, sa, v); chk("R9 saturate", v, 255);
            wr(0, sa, 32'h0000_0100);
            chk("R11 no kick on zero", {16'd0, kick0}, 0);
            rd(0, sa, v); chk("R9 zero add", v, 255);
            @(negedge clk); dec0 = 16'(1 << n);
            repeat (255) @(negedge clk);
            #1;
            chk("R10 drained", {24'd0, sc0[n*8 +: 8]}, 0);
            dec0 = '0;
            step();
            chk("R10 stays zero", {24'd0, sc0[n*8 +: 8]}, 0);
            @(negedge clk); a0 = sa; d0 = 32'd2; we0 = 1'b1; dec0 = 16'(1 << n);
            @(negedge clk); we0 = 1'b0; dec0 = '0; #1;
            chk("R10 add and dec", {24'd0, sc0[n*8 +: 8]}, 1);
        end
        for (int n = 0; n < N0; n++)
            chk("R9 counts independent", {24'd0, sc0[n*8 +: 8]}, 1);

        // R12: unmapped addresses
        wr(0, 12'h020, 32'h1234_5678);
        wr(0, 12'h00C, 32'hFFFF_FFFF);
        wr(0, 12'h040, 32'hFFFF_FFFF);
        wr(0, 12'h10C, 32'hFFFF_FFFF);
        wr(0, 12'h7FC, 32'hFFFF_FFFF);
        chk("R12 no kick", {16'd0, kick0}, 0);
        chk("R12 no reset", {16'd0, rst0}, 0);
        chk("R12 freeze", {16'd0, frz0}, 0);
        rd(0, 12'h020, v); chk("R12 word2 intact", v, 32'h1234_5678);
        rd(0, 12'h000, v); chk("R12 word0 intact", v, 0);
        rd(0, 12'h00C, v); chk("R12 read zero", v, 0);
        rd(0, 12'h7FC, v); chk("R12 read zero high", v, 0);
        chk("R12 start addr intact", sa0[31:0], 32'h8000_0000);

        // older layout
        wr(1, 12'h004, 32'h0000_000A);
        chk("R4 legacy freeze", {28'd0, frz1}, 32'hA);
        wr(1, 12'h000, 32'hFFFF_FFFF);
        chk("R5 legacy pulse", {28'd0, rst1}, 32'hF);
        step();
        chk("R5 legacy pulse ends", {28'd0, rst1}, 0);
        rd(1, 12'h000, v); chk("R6 legacy word0", v, 32'h3000_FFFF);
        chk("R6 legacy burst", {30'd0, b81, b1}, 32'h3);
        wr(1, 12'h008, 32'hFFFF_FFFF);
        chk("R3 legacy clr", {28'd0, frz1, b81, b1}, 0);
        wr(1, 12'h030, 32'h0000_FFFF);
        wr(1, 12'h034, 32'h0000_FFFF);
        chk("R12 legacy chctl ignored", {28'd0, frz1}, 0);
        rd(1, 12'h030, v); chk("R12 legacy chctl reads zero", v, 0);
        wr(1, 12'h014, 32'h000F_0000);
        chk("R7 legacy irq", {28'd0, irq1}, 32'hF);
        for (int n = 0; n < N1; n++) begin
            wr(1, 12'(32'h050 + n*32'h70), 32'hC0DE_0000 + 32'(n));
            rd(1, 12'(32'h050 + n*32'h70), v); chk("R8 legacy nxt", v, 32'hC0DE_0000 + 32'(n));
            chk("R8 legacy start", sa1[n*32 +: 32], 32'hC0DE_0000 + 32'(n));
            wr(1, 12'(32'h080 + n*32'h70), 32'(n + 1));
            chk("R11 legacy kick", {28'd0, kick1}, 32'h1 << n);
            rd(1, 12'(32'h080 + n*32'h70), v); chk("R9 legacy sema", v, 32'(n + 1));
        end
        rd(1, 12'h110, v); chk("R12 legacy new base unmapped", v, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule